// File: doc/BRIEF.md
# Converter Conversion-Start Controller

This block is the control side of a successive-approximation analog-to-digital converter. Its inputs are a chip enable (active high), a chip select (active low), a read/convert line whose low level requests a conversion, and a byte-address line. A conversion begins when all three start conditions hold together. The last of the three inputs to reach its active level is the one that triggers the start, so any one of them, or all three at once, may be driven dynamically. At that moment the byte-address line is captured to choose either a short conversion of eight bit decisions or a full conversion of twelve decisions.

While a conversion runs, the status output is high. The block paces one bit-decision strobe every `CYC_PER_STEP` clock cycles. Each strobe carries the index of the bit being decided, MSB first. A full conversion also inserts `CORR_STEPS` correction strobes after the eighth decision. Start requests that arrive while status is high are ignored. When the last strobe has been issued, status falls and a one-cycle done pulse tells the result register to load. A low-nibble fill value describes how a twelve-bit read of a short result looks.

In stand-alone use, chip enable is tied high and chip select and byte address are tied low. A low pulse on the read/convert line alone then starts a full conversion. A synchronous reset stands in for power-up reset.

Top module: `adc_start_ctrl`

## Requirements
- R1: A start occurs only when `ce_i`=1, `cs_n_i`=0 and `rc_i`=0 all hold at once. The start is triggered by whichever of the three reaches its active level last, including all three changing together.
- R2: With the default two synchronizer stages, `sts_o` is first seen high in the third clock cycle after the completing input change (SYNC_STAGES+1 cycles).
- R3: If `ao_i`=0 at the start, the conversion is a full one: 12+CORR_STEPS strobes, with `sts_o` high for (12+CORR_STEPS)*CYC_PER_STEP cycles. If `ao_i`=1, it is a short one: 8 strobes, with `sts_o` high for 8*CYC_PER_STEP cycles.
- R4: Strobe k carries `step_idx_o`=11-k for the first 8 strobes. In a full conversion the next CORR_STEPS strobes carry `step_idx_o`=4 with `step_corr_o`=1, and the last four carry indices 3,2,1,0 with `step_corr_o`=0. `step_corr_o` is never 1 in a short conversion.
- R5: A new start condition while `sts_o` is high has no effect: the length and strobe count of the running conversion are unchanged.
- R6: Only `ao_i` is latched, and only at the start. Changing `ao_i` during a conversion changes neither its length nor `fill_o`.
- R7: Holding the inputs in the start state does not start again after a conversion ends. The combined condition must go inactive and then active.
- R8: `done_o` is high for exactly one cycle: the first cycle in which `sts_o` is low after a conversion. It is low at every other time.
- R9: `fill_o` is 4'b1000 after a short start and 4'b0000 after a full start. It holds that value until the next start.
- R10: While `rst` is high, and in the cycle after it is applied, `sts_o`, `done_o`, `step_stb_o` and `fill_o` are all 0. This is true even during a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Chip enable, active high, asynchronous to clk |
| cs_n_i | input | 1 | Chip select, active low, asynchronous to clk |
| rc_i | input | 1 | Read/convert, low requests a conversion |
| ao_i | input | 1 | Byte address, latched at start: 1 = short, 0 = full |
| sts_o | output | 1 | High while a conversion is in progress |
| done_o | output | 1 | One-cycle pulse as status falls |
| step_stb_o | output | 1 | One-cycle bit-decision strobe |
| step_idx_o | output | 4 | Bit index of the current strobe |
| step_corr_o | output | 1 | Current strobe is a correction step |
| fill_o | output | 4 | Low-nibble read value implied by the latched length |

## Verification
On every cycle, the assertions check the following:
- status can only rise after a detected start;
- a start is never detected in two cycles in a row;
- the latched length stays fixed while a conversion runs;
- the step counter stays below the length it selected;
- a short conversion never issues a correction strobe or an index below 4;
- the done pulse coincides with the falling edge of status.

Some behaviour only the bench scenarios can show. These are the exact latency from each input being the last one, the conversion lengths and index sequences, the restart attempt and the byte-address toggle during a conversion, the held inputs that must not retrigger, the stand-alone single-line pulse, and the reset in the middle of a conversion.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
   localparam int DEC_FULL  = 12;
   localparam int DEC_SHORT = 8;
   localparam int IDX_W     = 4;
   localparam int FILL_W    = 4;
   localparam logic [FILL_W-1:0] FILL_SHORT = 4'b1000;
   localparam logic [FILL_W-1:0] FILL_FULL  = 4'b0000;
   localparam int MAX_CORR  = 4;
   typedef logic [IDX_W-1:0] bit_idx_t;
endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
   parameter int N = 4,
   parameter int STAGES = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("adc_in_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (rst) sh <= {STAGES{RST_VAL[i]}};
         else     sh <= {sh[STAGES-2:0], d[i]};
      end
      assign q[i] = sh[STAGES-1];
   end
endmodule

// File: rtl/adc_start_detect.sv
module adc_start_detect (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic cs_n,
   input  logic rc,
   input  logic busy,
   output logic start_o
);
   logic cond, cond_q;

   assign cond = ce & ~cs_n & ~rc;

   always_ff @(posedge clk) begin
      if (rst) cond_q <= 1'b0;
      else     cond_q <= cond;
   end

   assign start_o = cond & ~cond_q & ~busy;

   // R7: a held condition yields at most one start
   assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (rst)
      start_o |=> !start_o);
endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq
   import adc_start_pkg::*;
#(
   parameter int CYC_PER_STEP = 4,
   parameter int CORR_STEPS = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              short_sel,
   output logic              busy_o,
   output logic              done_o,
   output logic              stb_o,
   output bit_idx_t          idx_o,
   output logic              corr_o,
   output logic [FILL_W-1:0] fill_o
);
   localparam int FULL_STEPS = DEC_FULL + CORR_STEPS;
   localparam int SW = $clog2(FULL_STEPS + 1);
   localparam int CW = (CYC_PER_STEP > 1) ? $clog2(CYC_PER_STEP) : 1;

   if (CYC_PER_STEP < 1) begin : g_bad_cyc
      $error("adc_step_seq: CYC_PER_STEP must be at least 1");
   end
   if (CORR_STEPS < 0 || CORR_STEPS > MAX_CORR) begin : g_bad_corr
      $error("adc_step_seq: CORR_STEPS out of range");
   end

   logic          busy, short_q, done_q;
   logic [CW-1:0] cyc_cnt;
   logic [SW-1:0] step_cnt;
   logic          last_step;

   assign stb_o = busy && (cyc_cnt == CW'(CYC_PER_STEP - 1));
   assign last_step = short_q ? (step_cnt == SW'(DEC_SHORT - 1))
                              : (step_cnt == SW'(FULL_STEPS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy     <= 1'b0;
         short_q  <= 1'b0;
         done_q   <= 1'b0;
         cyc_cnt  <= '0;
         step_cnt <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            busy     <= 1'b1;
            short_q  <= short_sel;
            cyc_cnt  <= '0;
            step_cnt <= '0;
         end else if (busy) begin
            if (stb_o) begin
               cyc_cnt <= '0;
               if (last_step) begin
                  busy     <= 1'b0;
                  done_q   <= 1'b1;
                  step_cnt <= '0;
               end else begin
                  step_cnt <= step_cnt + SW'(1);
               end
            end else begin
               cyc_cnt <= cyc_cnt + CW'(1);
            end
         end
      end
   end

   if (CORR_STEPS == 0) begin : g_plain
      always_comb begin
         idx_o  = IDX_W'(DEC_FULL - 1 - int'(step_cnt));
         corr_o = 1'b0;
      end
   end else begin : g_corr
      always_comb begin
         int s;
         s = int'(step_cnt);
         corr_o = 1'b0;
         if (short_q || s < DEC_SHORT) begin
            idx_o = IDX_W'(DEC_FULL - 1 - s);
         end else if (s < DEC_SHORT + CORR_STEPS) begin
            idx_o  = IDX_W'(DEC_FULL - DEC_SHORT);
            corr_o = 1'b1;
         end else begin
            idx_o = IDX_W'(DEC_FULL - 1 - (s - CORR_STEPS));
         end
      end
   end

   assign busy_o = busy;
   assign done_o = done_q;
   assign fill_o = short_q ? FILL_SHORT : FILL_FULL;

   // R8: done marks the first idle cycle after a conversion
   assert_done_at_fall_R8: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!busy_o && $past(busy_o)));
   // R6: length latch is frozen while converting
   assert_len_frozen_R6: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(short_q));
   // R3: step counter stays inside the selected length
   assert_step_bound_R3: assert property (@(posedge clk) disable iff (rst)
      busy |-> (step_cnt < (short_q ? SW'(DEC_SHORT) : SW'(FULL_STEPS))));
   // R4: short conversions decide only the upper eight bits
   assert_short_idx_R4: assert property (@(posedge clk) disable iff (rst)
      (stb_o && short_q) |-> (idx_o >= bit_idx_t'(DEC_FULL - DEC_SHORT) && !corr_o));
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
   import adc_start_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CYC_PER_STEP = 4,
   parameter int CORR_STEPS = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce_i,
   input  logic              cs_n_i,
   input  logic              rc_i,
   input  logic              ao_i,
   output logic              sts_o,
   output logic              done_o,
   output logic              step_stb_o,
   output logic [IDX_W-1:0]  step_idx_o,
   output logic              step_corr_o,
   output logic [FILL_W-1:0] fill_o
);
   logic [3:0] raw, syn;
   logic       start, busy;

   assign raw = {ao_i, rc_i, cs_n_i, ce_i};

   adc_in_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
      .clk(clk), .rst(rst), .d(raw), .q(syn)
   );

   adc_start_detect u_det (
      .clk(clk), .rst(rst), .ce(syn[0]), .cs_n(syn[1]), .rc(syn[2]),
      .busy(busy), .start_o(start)
   );

   adc_step_seq #(.CYC_PER_STEP(CYC_PER_STEP), .CORR_STEPS(CORR_STEPS)) u_seq (
      .clk(clk), .rst(rst), .start(start), .short_sel(syn[3]),
      .busy_o(busy), .done_o(done_o), .stb_o(step_stb_o),
      .idx_o(step_idx_o), .corr_o(step_corr_o), .fill_o(fill_o)
   );

   assign sts_o = busy;

   // R1: status only rises after a detected start
   assert_rise_needs_start_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(sts_o) |-> $past(start));
endmodule

// File: tb/sim_adc_start_ctrl.sv
`timescale 1ns/1ps
module sim_adc_start_ctrl;
   localparam int SYNC = 2;
   localparam int CYC = 4;
   localparam int CORR = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ce = 1'b0, cs_n = 1'b1, rc = 1'b1, ao = 1'b0;
   logic sts, done, stb, corr;
   logic [3:0] idx, fill;

   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;

   adc_start_ctrl #(.SYNC_STAGES(SYNC), .CYC_PER_STEP(CYC), .CORR_STEPS(CORR)) u0 (
      .clk(clk), .rst(rst), .ce_i(ce), .cs_n_i(cs_n), .rc_i(rc), .ao_i(ao),
      .sts_o(sts), .done_o(done), .step_stb_o(stb), .step_idx_o(idx),
      .step_corr_o(corr), .fill_o(fill)
   );

   // {sel[1:0], ao, restart}; sel 0=ce last, 1=cs last, 2=rc last, 3=all at once
   localparam logic [3:0] VEC [6] = '{
      {2'd0, 1'b0, 1'b0}, {2'd1, 1'b1, 1'b0}, {2'd2, 1'b0, 1'b1},
      {2'd2, 1'b1, 1'b1}, {2'd3, 1'b0, 1'b0}, {2'd0, 1'b1, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_in(input int sel, input bit act);
      case (sel)
         0: ce = act;
         1: cs_n = ~act;
         2: rc = ~act;
         default: begin ce = act; cs_n = ~act; rc = ~act; end
      endcase
   endtask

   function automatic int exp_idx(input int k, input bit shrt, output bit c);
      c = 1'b0;
      if (shrt || k < 8) return 11 - k;
      if (k < 8 + CORR) begin c = 1'b1; return 4; end
      return 11 - (k - CORR);
   endfunction

   task automatic observe(input int sel, input bit restart, input bit pulse_rc,
                          input bit shrt, input string tag);
      int lat, len, nstb, bad_idx, ncorr, bad_done, k;
      bit ec;
      int ei;
      lat = 0; len = 0; nstb = 0; bad_idx = 0; ncorr = 0; bad_done = 0; k = 0;
      do begin
         @(negedge clk);
         lat++;
         if (pulse_rc && lat == 1) rc = 1'b1;
      end while (!sts && lat < 100);
      chk(lat == SYNC + 1, {tag, " R2 latency"}, lat, SYNC + 1);
      while (sts && len < 1000) begin
         len++;
         if (done) bad_done++;
         if (stb) begin
            nstb++;
            ei = exp_idx(k, shrt, ec);
            if (int'(idx) != ei || corr != ec) bad_idx++;
            if (corr) ncorr++;
            k++;
         end
         if (restart && len == 5) begin set_in(sel, 1'b0); ao = ~ao; end
         if (restart && len == 8) set_in(sel, 1'b1);
         @(negedge clk);
      end
      chk(len == (shrt ? 8 : 12 + CORR) * CYC, {tag, " R3 length (R5 R6)"},
          len, (shrt ? 8 : 12 + CORR) * CYC);
      chk(nstb == (shrt ? 8 : 12 + CORR), {tag, " R3 strobes"}, nstb, shrt ? 8 : 12 + CORR);
      chk(bad_idx == 0 && ncorr == (shrt ? 0 : CORR), {tag, " R4 index order"}, bad_idx, 0);
      chk(done == 1'b1 && bad_done == 0, {tag, " R8 done at fall"}, int'(done), 1);
      chk(fill == (shrt ? 4'b1000 : 4'b0000), {tag, " R9 fill"}, int'(fill),
          shrt ? 8 : 0);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R8 done one cycle"}, int'(done), 0);
   endtask

   initial begin
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(sts == 0 && done == 0 && stb == 0 && fill == 0, "R10 reset state",
          int'({sts, done, stb, fill}), 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      chk(sts == 1'b0, "R1 idle inputs give no start", int'(sts), 0);

      // table of start scenarios
      for (int v = 0; v < 6; v++) begin
         int sel;
         bit a, rs;
         sel = int'(VEC[v][3:2]);
         a = VEC[v][1];
         rs = VEC[v][0];
         ce = 1'b1; cs_n = 1'b0; rc = 1'b0; ao = a;
         set_in(sel, 1'b0);
         repeat (6) @(negedge clk);
         chk(sts == 1'b0, "R1 incomplete condition", int'(sts), 0);
         set_in(sel, 1'b1);
         observe(sel, rs, 1'b0, a, $sformatf("vec%0d", v));
      end

      // R7: inputs are still held in the start state
      repeat (40) @(negedge clk);
      chk(sts == 1'b0, "R7 held inputs do not retrigger", int'(sts), 0);

      // stand-alone: single low pulse on rc
      ce = 1'b1; cs_n = 1'b0; ao = 1'b0; rc = 1'b1;
      repeat (6) @(negedge clk);
      rc = 1'b0;
      observe(2, 1'b0, 1'b1, 1'b0, "R1 stand-alone pulse");

      // R10: reset in the middle of a short conversion
      ao = 1'b1; rc = 1'b1;
      repeat (6) @(negedge clk);
      rc = 1'b0;
      repeat (10) @(negedge clk);
      chk(sts == 1'b1 && fill == 4'b1000, "R9 fill during short", int'(fill), 8);
      rst = 1'b1;
      @(negedge clk);
      chk(sts == 0 && done == 0 && stb == 0 && fill == 0, "R10 reset mid-conversion",
          int'({sts, done, stb, fill}), 0);
      rst = 1'b0;
      rc = 1'b1;
      repeat (60) @(negedge clk);
      chk(sts == 1'b0, "R10 stays idle after reset", int'(sts), 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule